// File: doc/BRIEF.md
# ATM Cell Transmit Buffer with Loopback Routing

This block takes 53-byte ATM cells from an upstream transmit port, one byte per accepted cycle, and builds each cell in a single-cell assembly store. It forwards a cell only after the whole cell has been stored, streaming it one byte per cycle with a start flag on the first byte. The cell goes to one of three places, chosen by a mode input. In normal mode it goes to the line transmit output. In PHY loopback it goes back to the upstream receive output. In line loopback, upstream cells are drained and counted, and bytes arriving on the line receive input are turned around onto the line transmit output.

A stop input throttles the upstream side at two levels. With the soft level, the cell-available flag drops but a cell already started is still taken to completion and sent. With the hard level, byte acceptance freezes in the middle of a cell. Assembly then resumes where it stopped when the stop is lifted, unless a new start-of-cell byte arrives first, in which case the partial cell is thrown away. Two 16-bit wrapping counters count forwarded upstream cells and complete line receive cells.

The assembler has three states. EMPTY goes to FILL on an accepted start byte. FILL goes back to FILL at byte 1 on an accepted start byte, which drops the partial cell, and goes to READY on byte 52. READY goes to EMPTY when the forwarder releases the cell. The forwarder has two states. IDLE goes to SEND when the assembler is in READY. SEND goes to IDLE after byte 52.

Top module: `cell_tx_loop`

## Requirements
- R1: `up_tx_clav` is 1 only while the assembly store is empty and `ctrl_stop` is 0. A cell is 53 bytes. In the empty state only a byte with `up_tx_soc`=1 is accepted, and it becomes byte 0.
- R2: With `ctrl_stop`=1 and `ctrl_hard`=0, a cell that was already started is still accepted to completion and forwarded. A new start byte arriving while the store is empty is ignored: no output and no count.
- R3: With `ctrl_stop`=1 and `ctrl_hard`=1, every upstream byte is ignored, including start bytes. When the stop is cleared, assembly continues at the next byte position of the interrupted cell.
- R4: An accepted byte with `up_tx_soc`=1 that arrives while a partial cell is held discards the partial cell and becomes byte 0 of a new cell.
- R5: A cell is output only after all 53 bytes are stored. It is sent as 53 consecutive valid bytes, with the start flag set only on byte 0, in the order the bytes were stored.
- R6: `mode_sel` selects the route. 2'b00 is normal: cells go to line tx, and line rx bytes appear on up rx one cycle later. 2'b01 is PHY loopback: cells go to up rx, and line rx bytes are dropped. 2'b10 is line loopback: line rx bytes appear on line tx one cycle later, and upstream cells are drained without output. 2'b11 acts as normal.
- R7: A new `mode_sel` value takes effect only while no cell is being forwarded, no line rx cell is partly received, and `line_rx_valid` is 0. A cell already being forwarded is never split between routes. A cell that completes after a mode change uses the new route.
- R8: `tx_cell_count` increases by exactly 1 for each assembled cell once it has been fully forwarded or drained. It never counts a discarded or ignored partial cell, and it wraps modulo 2^16.
- R9: `rx_cell_count` increases by 1 on the 53rd byte of a line rx cell that began with `line_rx_soc`=1, and it wraps modulo 2^16.
- R10: After reset both counters are 0, all valid outputs are 0, the route is normal, and `up_tx_clav` equals the inverse of `ctrl_stop`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_stop | input | 1 | Throttle control bit |
| ctrl_hard | input | 1 | Selects the hard (freeze) throttle level |
| mode_sel | input | 2 | Route select (00 normal, 01 PHY loop, 10 line loop) |
| up_tx_enb | input | 1 | Upstream byte write strobe |
| up_tx_soc | input | 1 | Upstream start-of-cell flag |
| up_tx_data | input | 8 | Upstream cell byte |
| up_tx_clav | output | 1 | A whole cell can be accepted |
| line_tx_valid | output | 1 | Line transmit byte valid |
| line_tx_soc | output | 1 | Line transmit start-of-cell |
| line_tx_data | output | 8 | Line transmit byte |
| line_rx_valid | input | 1 | Line receive byte valid |
| line_rx_soc | input | 1 | Line receive start-of-cell |
| line_rx_data | input | 8 | Line receive byte |
| up_rx_valid | output | 1 | Upstream receive byte valid |
| up_rx_soc | output | 1 | Upstream receive start-of-cell |
| up_rx_data | output | 8 | Upstream receive byte |
| tx_cell_count | output | 16 | Forwarded upstream cell count |
| rx_cell_count | output | 16 | Completed line receive cell count |

## Verification
On every cycle the assertions check the following: a hard freeze holds the assembly position, a start byte in FILL restarts at position 1, READY persists until release, SEND only runs on a complete cell, the route holds while a receive cell is open, and both counters advance by at most one. Only the bench scenarios can show the byte-exact content and order of each forwarded cell on the correct output. They also show that a frozen cell is resumed correctly, that a mode change made during a transfer leaves that cell on its original route, and that ignored or discarded bytes never reach an output or a counter.

// File: rtl/cell_loop_pkg.sv
package cell_loop_pkg;
    typedef enum logic [1:0] {
        RT_NORMAL    = 2'b00,
        RT_PHY_LOOP  = 2'b01,
        RT_LINE_LOOP = 2'b10
    } route_e;

    typedef enum logic [1:0] {
        AS_EMPTY,
        AS_FILL,
        AS_READY
    } asm_state_e;

    typedef enum logic {
        FS_IDLE,
        FS_SEND
    } fwd_state_e;

    function automatic route_e to_route(input logic [1:0] sel);
        case (sel)
            2'b01:   return RT_PHY_LOOP;
            2'b10:   return RT_LINE_LOOP;
            default: return RT_NORMAL;
        endcase
    endfunction
endpackage

// File: rtl/cell_assembler.sv
module cell_assembler
    import cell_loop_pkg::*;
#(
    parameter int CELL_BYTES = 53,
    parameter int DATA_W     = 8,
    localparam int IDX_W     = $clog2(CELL_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stop_i,
    input  logic              hard_i,
    input  logic              enb_i,
    input  logic              soc_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [IDX_W-1:0]  rd_idx_i,
    input  logic              release_i,
    output logic              clav_o,
    output logic              ready_o,
    output logic [DATA_W-1:0] rd_data_o
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(CELL_BYTES - 1);

    asm_state_e        state_q, state_d;
    logic [IDX_W-1:0]  wr_q, wr_d, wa;
    logic              we;
    logic              take;
    logic [DATA_W-1:0] mem [CELL_BYTES];

    assign take = enb_i && !(stop_i && hard_i);

    always_comb begin
        state_d = state_q;
        wr_d    = wr_q;
        we      = 1'b0;
        wa      = '0;
        unique case (state_q)
            AS_EMPTY: begin
                if (take && soc_i && !stop_i) begin
                    we      = 1'b1;
                    wr_d    = IDX_W'(1);
                    state_d = AS_FILL;
                end
            end
            AS_FILL: begin
                if (take) begin
                    we = 1'b1;
                    if (soc_i) begin
                        wr_d = IDX_W'(1);
                    end else begin
                        wa = wr_q;
                        if (wr_q == LAST) begin
                            wr_d    = '0;
                            state_d = AS_READY;
                        end else begin
                            wr_d = wr_q + IDX_W'(1);
                        end
                    end
                end
            end
            AS_READY: begin
                if (release_i) state_d = AS_EMPTY;
            end
            default: state_d = AS_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= AS_EMPTY;
            wr_q    <= '0;
        end else begin
            state_q <= state_d;
            wr_q    <= wr_d;
        end
    end

    always_ff @(posedge clk) begin
        if (we) mem[wa] <= data_i;
    end

    assign clav_o    = (state_q == AS_EMPTY) && !stop_i;
    assign ready_o   = (state_q == AS_READY);
    assign rd_data_o = mem[rd_idx_i];

    AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == AS_FILL && stop_i && hard_i) |=> (state_q == AS_FILL && $stable(wr_q))); // R3
    AST_SOC_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == AS_FILL && take && soc_i) |=> (state_q == AS_FILL && wr_q == IDX_W'(1))); // R4
    AST_READY_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == AS_READY && !release_i) |=> (state_q == AS_READY)); // R5
endmodule

// File: rtl/rx_cell_tracker.sv
module rx_cell_tracker #(
    parameter int CELL_BYTES = 53,
    parameter int CNT_W      = 16,
    localparam int IDX_W     = $clog2(CELL_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_i,
    input  logic             soc_i,
    output logic             boundary_o,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(CELL_BYTES - 1);

    logic [IDX_W-1:0] pos_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q <= '0;
            cnt_o <= '0;
        end else if (valid_i) begin
            if (soc_i) begin
                pos_q <= IDX_W'(1);
            end else if (pos_q == LAST) begin
                pos_q <= '0;
                cnt_o <= cnt_o + CNT_W'(1);
            end else if (pos_q != '0) begin
                pos_q <= pos_q + IDX_W'(1);
            end
        end
    end

    assign boundary_o = (pos_q == '0) && !valid_i;

    AST_RX_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_o != $past(cnt_o)) |-> (cnt_o == $past(cnt_o) + CNT_W'(1))); // R9
endmodule

// File: rtl/cell_router.sv
module cell_router
    import cell_loop_pkg::*;
#(
    parameter int CELL_BYTES = 53,
    parameter int DATA_W     = 8,
    parameter int CNT_W      = 16,
    localparam int IDX_W     = $clog2(CELL_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_i,
    input  logic              rx_boundary_i,
    input  logic              ready_i,
    input  logic [DATA_W-1:0] rd_data_i,
    input  logic              lrx_valid_i,
    input  logic              lrx_soc_i,
    input  logic [DATA_W-1:0] lrx_data_i,
    output logic [IDX_W-1:0]  rd_idx_o,
    output logic              release_o,
    output logic              ltx_valid_o,
    output logic              ltx_soc_o,
    output logic [DATA_W-1:0] ltx_data_o,
    output logic              urx_valid_o,
    output logic              urx_soc_o,
    output logic [DATA_W-1:0] urx_data_o,
    output logic [CNT_W-1:0]  tx_cnt_o
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(CELL_BYTES - 1);

    fwd_state_e       fstate_q, fstate_d;
    logic [IDX_W-1:0] rd_q, rd_d;
    route_e           route_q;
    logic             upd;

    assign upd       = (fstate_q == FS_IDLE) && rx_boundary_i;
    assign release_o = (fstate_q == FS_SEND) && (rd_q == LAST);
    assign rd_idx_o  = rd_q;

    always_comb begin
        fstate_d = fstate_q;
        rd_d     = rd_q;
        unique case (fstate_q)
            FS_IDLE: begin
                if (ready_i) begin
                    fstate_d = FS_SEND;
                    rd_d     = '0;
                end
            end
            FS_SEND: begin
                if (rd_q == LAST) begin
                    fstate_d = FS_IDLE;
                    rd_d     = '0;
                end else begin
                    rd_d = rd_q + IDX_W'(1);
                end
            end
            default: fstate_d = FS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fstate_q <= FS_IDLE;
            rd_q     <= '0;
            route_q  <= RT_NORMAL;
        end else begin
            fstate_q <= fstate_d;
            rd_q     <= rd_d;
            if (upd) route_q <= to_route(mode_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ltx_valid_o <= 1'b0;
            ltx_soc_o   <= 1'b0;
            ltx_data_o  <= '0;
            urx_valid_o <= 1'b0;
            urx_soc_o   <= 1'b0;
            urx_data_o  <= '0;
            tx_cnt_o    <= '0;
        end else begin
            ltx_valid_o <= 1'b0;
            ltx_soc_o   <= 1'b0;
            urx_valid_o <= 1'b0;
            urx_soc_o   <= 1'b0;
            if (release_o) tx_cnt_o <= tx_cnt_o + CNT_W'(1);
            if (fstate_q == FS_SEND) begin
                unique case (route_q)
                    RT_NORMAL: begin
                        ltx_valid_o <= 1'b1;
                        ltx_soc_o   <= (rd_q == '0);
                        ltx_data_o  <= rd_data_i;
                    end
                    RT_PHY_LOOP: begin
                        urx_valid_o <= 1'b1;
                        urx_soc_o   <= (rd_q == '0);
                        urx_data_o  <= rd_data_i;
                    end
                    default: ;
                endcase
            end
            if (lrx_valid_i) begin
                unique case (route_q)
                    RT_NORMAL: begin
                        urx_valid_o <= 1'b1;
                        urx_soc_o   <= lrx_soc_i;
                        urx_data_o  <= lrx_data_i;
                    end
                    RT_LINE_LOOP: begin
                        ltx_valid_o <= 1'b1;
                        ltx_soc_o   <= lrx_soc_i;
                        ltx_data_o  <= lrx_data_i;
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_SEND_NEEDS_CELL: assert property (@(posedge clk) disable iff (!rst_n)
        (fstate_q == FS_SEND) |-> ready_i); // R5
    AST_ROUTE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_boundary_i || fstate_q == FS_SEND) |=> $stable(route_q)); // R7
    AST_TX_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_cnt_o != $past(tx_cnt_o)) |-> (tx_cnt_o == $past(tx_cnt_o) + CNT_W'(1))); // R8
endmodule

// File: rtl/cell_tx_loop.sv
module cell_tx_loop #(
    parameter int CELL_BYTES = 53,
    parameter int DATA_W     = 8,
    parameter int CNT_W      = 16,
    localparam int IDX_W     = $clog2(CELL_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_stop,
    input  logic              ctrl_hard,
    input  logic [1:0]        mode_sel,
    input  logic              up_tx_enb,
    input  logic              up_tx_soc,
    input  logic [DATA_W-1:0] up_tx_data,
    output logic              up_tx_clav,
    output logic              line_tx_valid,
    output logic              line_tx_soc,
    output logic [DATA_W-1:0] line_tx_data,
    input  logic              line_rx_valid,
    input  logic              line_rx_soc,
    input  logic [DATA_W-1:0] line_rx_data,
    output logic              up_rx_valid,
    output logic              up_rx_soc,
    output logic [DATA_W-1:0] up_rx_data,
    output logic [CNT_W-1:0]  tx_cell_count,
    output logic [CNT_W-1:0]  rx_cell_count
);
    logic              ready;
    logic              release_cell;
    logic              rx_boundary;
    logic [IDX_W-1:0]  rd_idx;
    logic [DATA_W-1:0] rd_data;

    cell_assembler #(.CELL_BYTES(CELL_BYTES), .DATA_W(DATA_W)) u_asm (
        .clk       (clk),
        .rst_n     (rst_n),
        .stop_i    (ctrl_stop),
        .hard_i    (ctrl_hard),
        .enb_i     (up_tx_enb),
        .soc_i     (up_tx_soc),
        .data_i    (up_tx_data),
        .rd_idx_i  (rd_idx),
        .release_i (release_cell),
        .clav_o    (up_tx_clav),
        .ready_o   (ready),
        .rd_data_o (rd_data)
    );

    rx_cell_tracker #(.CELL_BYTES(CELL_BYTES), .CNT_W(CNT_W)) u_rxt (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid_i    (line_rx_valid),
        .soc_i      (line_rx_soc),
        .boundary_o (rx_boundary),
        .cnt_o      (rx_cell_count)
    );

    cell_router #(.CELL_BYTES(CELL_BYTES), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_rtr (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode_i        (mode_sel),
        .rx_boundary_i (rx_boundary),
        .ready_i       (ready),
        .rd_data_i     (rd_data),
        .lrx_valid_i   (line_rx_valid),
        .lrx_soc_i     (line_rx_soc),
        .lrx_data_i    (line_rx_data),
        .rd_idx_o      (rd_idx),
        .release_o     (release_cell),
        .ltx_valid_o   (line_tx_valid),
        .ltx_soc_o     (line_tx_soc),
        .ltx_data_o    (line_tx_data),
        .urx_valid_o   (up_rx_valid),
        .urx_soc_o     (up_rx_soc),
        .urx_data_o    (up_rx_data),
        .tx_cnt_o      (tx_cell_count)
    );
endmodule

// File: tb/cell_tx_loop_tb_top.sv
`timescale 1ns/1ps
module cell_tx_loop_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctrl_stop = 1'b0, ctrl_hard = 1'b0;
    logic [1:0] mode_sel = 2'b00;
    logic       up_tx_enb = 1'b0, up_tx_soc = 1'b0;
    logic [7:0] up_tx_data = '0;
    logic       up_tx_clav;
    logic       line_tx_valid, line_tx_soc;
    logic [7:0] line_tx_data;
    logic       line_rx_valid = 1'b0, line_rx_soc = 1'b0;
    logic [7:0] line_rx_data = '0;
    logic       up_rx_valid, up_rx_soc;
    logic [7:0] up_rx_data;
    logic [15:0] tx_cell_count, rx_cell_count;

    int checks = 0;
    int failures = 0;
    int exp_tx = 0;
    int exp_rx = 0;
    logic [8:0] line_q[$];
    logic [8:0] up_q[$];

    always #2.5 clk = ~clk;

    cell_tx_loop dut_i (
        .clk(clk), .rst_n(rst_n), .ctrl_stop(ctrl_stop), .ctrl_hard(ctrl_hard),
        .mode_sel(mode_sel), .up_tx_enb(up_tx_enb), .up_tx_soc(up_tx_soc),
        .up_tx_data(up_tx_data), .up_tx_clav(up_tx_clav),
        .line_tx_valid(line_tx_valid), .line_tx_soc(line_tx_soc), .line_tx_data(line_tx_data),
        .line_rx_valid(line_rx_valid), .line_rx_soc(line_rx_soc), .line_rx_data(line_rx_data),
        .up_rx_valid(up_rx_valid), .up_rx_soc(up_rx_soc), .up_rx_data(up_rx_data),
        .tx_cell_count(tx_cell_count), .rx_cell_count(rx_cell_count)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int base, input int i);
        return 8'(base * 7 + i * 3 + 1);
    endfunction

    // dest: 0 line tx, 1 upstream rx, 2 no output
    task automatic push_exp(input int dest, input logic s, input logic [7:0] d);
        if (dest == 0) line_q.push_back({s, d});
        else if (dest == 1) up_q.push_back({s, d});
    endtask

    task automatic up_byte(input logic s, input logic [7:0] d);
        @(negedge clk);
        up_tx_enb = 1'b1; up_tx_soc = s; up_tx_data = d;
    endtask

    task automatic up_idle();
        @(negedge clk);
        up_tx_enb = 1'b0; up_tx_soc = 1'b0;
    endtask

    task automatic send_cell(input int base, input int dest);
        for (int i = 0; i < 53; i++) begin
            up_byte(i == 0, pat(base, i));
            push_exp(dest, i == 0, pat(base, i));
        end
        up_idle();
    endtask

    task automatic rx_cell(input int base, input int dest);
        for (int i = 0; i < 53; i++) begin
            @(negedge clk);
            line_rx_valid = 1'b1; line_rx_soc = (i == 0); line_rx_data = pat(base, i);
            push_exp(dest, i == 0, pat(base, i));
        end
        @(negedge clk);
        line_rx_valid = 1'b0; line_rx_soc = 1'b0;
    endtask

    task automatic settle();
        repeat (70) @(negedge clk);
    endtask

    task automatic chk_counts(input string req);
        chk(tx_cell_count == 16'(exp_tx), req, "tx_cell_count", int'(tx_cell_count), exp_tx);
        chk(rx_cell_count == 16'(exp_rx), req, "rx_cell_count", int'(rx_cell_count), exp_rx);
    endtask

    // Scoreboard monitors (R5 content/order, R6 routing)
    always @(negedge clk) begin
        if (rst_n && line_tx_valid) begin
            if (line_q.size() == 0) begin
                chk(1'b0, "R6", "unexpected line_tx byte", int'(line_tx_data), -1);
            end else begin
                logic [8:0] e;
                e = line_q.pop_front();
                chk({line_tx_soc, line_tx_data} == e, "R5", "line_tx soc+data",
                    int'({line_tx_soc, line_tx_data}), int'(e));
            end
        end
        if (rst_n && up_rx_valid) begin
            if (up_q.size() == 0) begin
                chk(1'b0, "R6", "unexpected up_rx byte", int'(up_rx_data), -1);
            end else begin
                logic [8:0] e;
                e = up_q.pop_front();
                chk({up_rx_soc, up_rx_data} == e, "R5", "up_rx soc+data",
                    int'({up_rx_soc, up_rx_data}), int'(e));
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        // R10: reset state
        chk(up_tx_clav == 1'b1, "R10", "clav after reset", int'(up_tx_clav), 1);
        chk(!line_tx_valid && !up_rx_valid, "R10", "valids after reset",
            int'({line_tx_valid, up_rx_valid}), 0);
        chk_counts("R10");

        // R1 R5 R6: normal cell to line
        send_cell(1, 0); exp_tx++;
        settle(); chk_counts("R8");
        chk(up_tx_clav == 1'b1, "R1", "clav when empty", int'(up_tx_clav), 1);

        // R1: bytes without soc in the empty state are ignored
        for (int i = 0; i < 10; i++) up_byte(1'b0, 8'(i));
        up_idle(); settle();
        chk(tx_cell_count == 16'(exp_tx), "R1", "no-soc bytes ignored", int'(tx_cell_count), exp_tx);

        // R6: normal mode line rx goes upstream; mode 11 acts as normal
        rx_cell(2, 1); exp_rx++;
        mode_sel = 2'b11;
        send_cell(3, 0); exp_tx++;
        settle(); chk_counts("R9");

        // R6: PHY loopback
        mode_sel = 2'b01;
        @(negedge clk);
        send_cell(4, 1); exp_tx++;
        rx_cell(5, 2); exp_rx++;
        settle(); chk_counts("R6");

        // R6: line loopback, upstream cells drained
        mode_sel = 2'b10;
        @(negedge clk);
        rx_cell(6, 0); exp_rx++;
        send_cell(7, 2); exp_tx++;
        settle(); chk_counts("R8");

        // R2: soft stop lets started cell finish
        mode_sel = 2'b00;
        @(negedge clk);
        for (int i = 0; i < 20; i++) begin
            up_byte(i == 0, pat(8, i)); push_exp(0, i == 0, pat(8, i));
        end
        up_idle();
        ctrl_stop = 1'b1; ctrl_hard = 1'b0;
        for (int i = 20; i < 53; i++) begin
            up_byte(1'b0, pat(8, i)); push_exp(0, 1'b0, pat(8, i));
        end
        up_idle(); exp_tx++;
        settle(); #1;
        chk(up_tx_clav == 1'b0, "R2", "clav with soft stop", int'(up_tx_clav), 0);
        chk_counts("R2");
        send_cell(9, 2);
        settle(); chk_counts("R2");
        ctrl_stop = 1'b0; #1;
        chk(up_tx_clav == 1'b1, "R1", "clav after stop cleared", int'(up_tx_clav), 1);

        // R3: hard freeze mid-cell, then resume
        for (int i = 0; i < 20; i++) begin
            up_byte(i == 0, pat(10, i)); push_exp(0, i == 0, pat(10, i));
        end
        up_idle();
        ctrl_stop = 1'b1; ctrl_hard = 1'b1;
        for (int i = 0; i < 10; i++) up_byte(i == 0, 8'hEE);
        up_idle();
        ctrl_stop = 1'b0; ctrl_hard = 1'b0;
        for (int i = 20; i < 53; i++) begin
            up_byte(1'b0, pat(10, i)); push_exp(0, 1'b0, pat(10, i));
        end
        up_idle(); exp_tx++;
        settle(); chk_counts("R3");

        // R4: short cell discarded by a new soc
        for (int i = 0; i < 15; i++) up_byte(i == 0, pat(11, i));
        send_cell(12, 0); exp_tx++;
        settle(); chk_counts("R4");

        // R7: mode change during forwarding does not split the cell
        send_cell(13, 0); exp_tx++;
        repeat (5) @(negedge clk);
        mode_sel = 2'b01;
        settle();
        send_cell(14, 1); exp_tx++;
        settle(); chk_counts("R7");

        chk(line_q.size() == 0, "R5", "line_tx items left", line_q.size(), 0);
        chk(up_q.size() == 0, "R5", "up_rx items left", up_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule